// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flags and Control

This block keeps the three interrupt sources of a real-time clock (periodic tick, alarm match and end of time update) as sticky flags, holds the clock's host-writable control byte, and drives one active-low interrupt request line. Single-cycle event pulses arrive from the periodic divider, the alarm comparator and the time counter. Each pulse sets its flag whether or not that source is enabled. The enables decide only whether a set flag pulls the interrupt line low.

The host writes and reads the control byte directly. It reads the status byte with a one-cycle strobe. The status byte shows the current flags and the combined request bit, and the read clears every flag on the following edge. An event that arrives in the same cycle as the clearing read is kept. The block also gates the periodic-rate clock onto a square-wave output under a control bit.

Top module: `rtc_irq_status`

## Requirements
- R1: After a synchronous active-low reset, the control byte reads 0x00, the status byte reads 0x00, irq_n is 1 and sqw_out is 0.
- R2: A control write stores all eight bits, and they read back on ctrl_rdata from the next cycle. The bits are: bit 7 hold-update (SET), bit 6 periodic enable, bit 5 alarm enable, bit 4 update-ended enable, bit 3 square-wave enable, bit 2 binary mode, bit 1 24-hour mode, bit 0 daylight-saving enable.
- R3: A write that takes bit 7 from 0 to 1 stores bit 4 as 0, whatever the written value. A write with bit 7 already 1 stores bit 4 as written.
- R4: A pulse on periodic_evt, alarm_evt or update_evt sets its flag on the next edge, even when the matching enable is 0.
- R5: The status byte has the combined request in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update-ended flag in bit 4. Bits 3 to 0 always read 0.
- R6: Status bit 7 equals (periodic flag AND bit 6) OR (alarm flag AND bit 5) OR (update flag AND bit 4), taken over the control byte. irq_n is the inverse of status bit 7.
- R7: A cycle with stat_rd high shows the flags before the read. On the next edge all three flags clear.
- R8: A flag whose event pulse comes in the same cycle as a status read is still set after that read.
- R9: sqw_out is 0 while control bit 3 is 0. While bit 3 is 1, sqw_out follows rate_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Current control byte |
| stat_rd | input | 1 | Status read strobe; clears flags |
| stat_rdata | output | 8 | Status byte |
| periodic_evt | input | 1 | Periodic tick pulse |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-ended pulse |
| rate_clk | input | 1 | Selected periodic-rate clock |
| sqw_out | output | 1 | Gated square wave |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is an event pulse that lands in the very cycle in which the host's status read clears the flags. The bench first sets every flag. It then raises stat_rd and exactly one event input in the same cycle, once for each source, and checks that only that flag is still set. The enable-and-flag interaction is swept over all 64 pairs of enable set and pending flag set, each combination built from event pulses.

// File: rtl/rtc_irq_pkg.sv
// Package: bit positions of the control and status bytes, shared by the
// register, the flag bank and the top level. Bit positions are fixed
// because host software decodes them.
package rtc_irq_pkg;
    localparam int BYTE_W      = 8;
    localparam int N_SRC       = 3;   // periodic, alarm, update-ended
    // control byte positions
    localparam int C_HOLD      = 7;
    localparam int C_EN_HI     = 6;   // enables occupy bits 6..4
    localparam int C_EN_LO     = C_EN_HI - N_SRC + 1;
    localparam int C_EN_UPD    = C_EN_LO;
    localparam int C_SQW_EN    = 3;
    // status byte positions
    localparam int S_REQ       = 7;
    localparam int S_FLAG_HI   = 6;
    localparam int S_FLAG_LO   = S_FLAG_HI - N_SRC + 1;
    // source index within flag/enable vectors: 2 periodic, 1 alarm, 0 update
    localparam int SRC_PER     = 2;
    localparam int SRC_ALM     = 1;
    localparam int SRC_UPD     = 0;
endpackage

// File: rtl/rtc_ctrl_reg.sv
// Control byte register. It stores host writes. A write that raises the
// hold-update bit forces the update-ended enable to 0.
// Assumes: writes are single-cycle strobes; reset is synchronous active-low.
module rtc_ctrl_reg
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctrl_q
);
    logic              hold_rise;
    logic [BYTE_W-1:0] next_val;

    // Detect a 0-to-1 change of the hold bit and build the stored value.
    always_comb begin
        hold_rise = wdata[C_HOLD] && !ctrl_q[C_HOLD];
        next_val  = wdata;
        if (hold_rise) next_val[C_EN_UPD] = 1'b0;
    end

    // Register update on write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= next_val;
    end

    // R3: when the hold bit rises, the update enable is already 0
    p_hold_clears_upd_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[C_HOLD]) |-> !ctrl_q[C_EN_UPD]);
    // R2: a plain write is stored as written
    p_write_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wdata[C_HOLD] && !ctrl_q[C_HOLD])) |=> ctrl_q == $past(wdata));
    // R2: no write, no change
    p_ctrl_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/rtc_flag_bank.sv
// Sticky event flags, one per interrupt source. An event pulse sets its
// flag; a status read clears all flags. An event in the read cycle wins.
// Assumes: event pulses are synchronous to clk.
module rtc_flag_bank
    import rtc_irq_pkg::*;
#(
    parameter int N = N_SRC
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Per-source set/clear flop; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q[i] <= 1'b0;
            else if (evt[i]) flag_q[i] <= 1'b1;
            else if (clr)    flag_q[i] <= 1'b0;
        end

        // R4: an event always sets its flag
        p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flag_q[i]);
        // R7: a read without a coincident event clears the flag
        p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !evt[i]) |=> !flag_q[i]);
        // R8: a set flag stays set unless read
        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr) |=> flag_q[i]);
    end
endmodule

// File: rtl/rtc_irq_status.sv
// Top level of the interrupt flag and control block. It joins the control
// register and the flag bank, forms the combined request, the status byte
// and the gated square wave.
// Assumes: rate_clk is a free-running clock from the divider (out of scope).
module rtc_irq_status
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    output logic [BYTE_W-1:0] ctrl_rdata,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] stat_rdata,
    input  logic              periodic_evt,
    input  logic              alarm_evt,
    input  logic              update_evt,
    input  logic              rate_clk,
    output logic              sqw_out,
    output logic              irq_n
);
    logic [BYTE_W-1:0] ctrl_q;
    logic [N_SRC-1:0]  evt_vec;
    logic [N_SRC-1:0]  flags;
    logic [N_SRC-1:0]  enables;
    logic              req;

    rtc_ctrl_reg i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (ctrl_wdata),
        .ctrl_q (ctrl_q)
    );

    rtc_flag_bank #(.N(N_SRC)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_vec),
        .clr    (stat_rd),
        .flag_q (flags)
    );

    // Gather event pulses and enables into source-indexed vectors.
    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_PER] = periodic_evt;
        evt_vec[SRC_ALM] = alarm_evt;
        evt_vec[SRC_UPD] = update_evt;
        enables          = ctrl_q[C_EN_HI:C_EN_LO];
    end

    // Combined request, status byte, square wave and outputs.
    always_comb begin
        req                             = |(flags & enables);
        stat_rdata                      = '0;
        stat_rdata[S_REQ]               = req;
        stat_rdata[S_FLAG_HI:S_FLAG_LO] = flags;
        irq_n                           = !req;
        sqw_out                         = ctrl_q[C_SQW_EN] && rate_clk;
        ctrl_rdata                      = ctrl_q;
    end

    // R6: a low request line needs at least one pending flag
    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (stat_rdata[S_FLAG_HI:S_FLAG_LO] != '0));
    // R9: square wave is low while disabled
    p_sqw_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[C_SQW_EN] |-> !sqw_out);
    // R7: after a read with no events, nothing is pending
    p_read_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !periodic_evt && !alarm_evt && !update_evt) |=> irq_n);
endmodule

// File: tb/test_rtc_irq_status.sv
module test_rtc_irq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       periodic_evt = 1'b0, alarm_evt = 1'b0, update_evt = 1'b0;
    logic       rate_clk = 1'b0;
    logic       sqw_out, irq_n;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rtc_irq_status i_rtc_irq_status (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] f);
        {periodic_evt, alarm_evt, update_evt} = f;
        @(negedge clk);
        {periodic_evt, alarm_evt, update_evt} = 3'b000;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ctrl", ctrl_rdata, 8'h00);
        chk("R1 status", stat_rdata, 8'h00);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        rate_clk = 1'b1; #1;
        chk("R1 sqw", {7'b0, sqw_out}, 8'h00);
        rate_clk = 1'b0;
        @(negedge clk);

        // R2 walking-one read-back over each control bit except hold (bit 7)
        for (int b = 0; b < 7; b++) begin
            wr_ctrl(8'h01 << b);
            chk("R2 readback", ctrl_rdata, 8'h01 << b);
        end
        wr_ctrl(8'h00);

        // R3 hold rising with update enable in data: update enable dropped
        wr_ctrl(8'h90);
        chk("R3 rise clears", ctrl_rdata, 8'h80);
        wr_ctrl(8'h9F);
        chk("R3 hold kept allows", ctrl_rdata, 8'h9F);
        wr_ctrl(8'h00);
        chk("R2 clear", ctrl_rdata, 8'h00);

        // R4 R5 R6 R7 sweep: every enable set against every flag set
        for (int en = 0; en < 8; en++) begin
            wr_ctrl({1'b0, en[2:0], 4'b0000});
            for (int f = 0; f < 8; f++) begin
                logic req;
                pulse(f[2:0]);
                req = |(f[2:0] & en[2:0]);
                chk("R4 R5 R6 status", stat_rdata, {req, f[2:0], 4'b0000});
                chk("R6 irq_n", {7'b0, irq_n}, {7'b0, !req});
                rd_stat();
                chk("R7 cleared", stat_rdata, 8'h00);
            end
        end

        // R8 event coincident with the clearing read survives
        wr_ctrl(8'h70);
        for (int s = 0; s < 3; s++) begin
            pulse(3'b111);
            stat_rd = 1'b1;
            {periodic_evt, alarm_evt, update_evt} = 3'b001 << s;
            chk("R7 read shows flags", stat_rdata, 8'hF0);
            @(negedge clk);
            stat_rd = 1'b0;
            {periodic_evt, alarm_evt, update_evt} = 3'b000;
            chk("R8 coincident kept", stat_rdata, {1'b1, 3'b001 << s, 4'b0000});
            rd_stat();
        end

        // R9 square-wave gating
        wr_ctrl(8'h00);
        for (int k = 0; k < 4; k++) begin
            rate_clk = k[0]; #1;
            chk("R9 gated low", {7'b0, sqw_out}, 8'h00);
        end
        wr_ctrl(8'h08);
        for (int k = 0; k < 4; k++) begin
            rate_clk = k[0]; #1;
            chk("R9 follows rate", {7'b0, sqw_out}, {7'b0, k[0]});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule